// File: doc/BRIEF.md
# Memory protection region checker

This block judges every memory access against eight programmable protection regions and flags any access the selected region does not permit. Software programs one region per write through a simple configuration port. A write carries the region's base address, its size code, an enable bit and a ten-bit attribute word. The attribute word holds the type-extension, cacheable, bufferable, shareable, access-permission and execute-never fields. A separate control write sets the global enable and the background enable.

For each access the caller presents the address, the access kind and the privilege level. In the same cycle, the block answers with allow or deny, the number of the winning region and that region's attribute word. Where regions overlap, the highest-numbered enabled region decides. An address that no enabled region covers falls to a background map. Only privileged accesses may use the background map, and only while the background enable is set. Instruction fetches and data accesses are checked against the same region table. A denied access is registered one cycle later as a memory-management fault, together with the faulting address and access kind.

Top module: `mem_guard`

## Requirements
- R1: After reset, all regions are disabled, both control bits are clear and `flt_valid` is 0. A `cfg_we` pulse writes base, size, enable and attribute word for region `cfg_idx`. A `ctl_we` pulse writes the global and background enables. Both writes take effect from the next cycle, and a disabled region never matches.
- R2: With size code N, a region spans 2^(N+1) bytes. It matches when the address bits above bit N equal the same bits of its base, so the base bits below the region size are ignored. Codes 0 to 3 never match, and code 31 covers the whole 4 GB space.
- R3: When several enabled regions match, the region with the highest number decides the result, the region number and the attributes.
- R4: With the checker enabled and no region matching, a privileged access is allowed only if the background enable is set. An unprivileged access is always denied. `hit_valid` is 0 in both cases, and `hit_region` and `hit_attr` read 0.
- R5: The access-permission field uses these codes. 000 gives no access. 001 gives privileged read/write only. 010 gives privileged read/write and unprivileged read. 011 gives read/write at both levels. 101 gives privileged read only. 110 and 111 give read only at both levels. 100 gives no access.
- R6: `acc_kind` uses 00 for a data read, 01 for a data write, and 1x for an instruction fetch. A fetch is judged by the read permission of the same region table. A fetch from a region whose execute-never bit is set is always denied.
- R7: On a region hit, `hit_region` gives the winning region and `hit_attr` gives its attribute word. The word is laid out as bit 9 execute-never, bits 8:6 access permission, bits 5:3 type extension, bit 2 shareable, bit 1 cacheable and bit 0 bufferable.
- R8: With the global enable clear, every access is allowed, `hit_valid` is 0, and `hit_region` and `hit_attr` read 0.
- R9: One cycle after a cycle with `acc_valid` high and `acc_ok` low, `flt_valid` is 1 and `flt_addr`/`flt_kind` hold that access's address and kind. After any other cycle, `flt_valid` is 0.
- R10: Rewriting a region at run time changes the outcome of the very next access to its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_en_in | input | 1 | Global checker enable value |
| ctl_bg_in | input | 1 | Background-map enable value |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | 3 | Region number to write |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code N (2^(N+1) bytes) |
| cfg_en | input | 1 | Region enable |
| cfg_attr | input | 10 | Attribute word (layout in R7) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | Access kind (codes in R6) |
| acc_priv | input | 1 | Access is privileged |
| acc_ok | output | 1 | Access allowed |
| hit_valid | output | 1 | An enabled region matched |
| hit_region | output | 3 | Winning region number |
| hit_attr | output | 10 | Winning region's attribute word |
| flt_valid | output | 1 | Registered memory-management fault |
| flt_addr | output | 32 | Address of the faulting access |
| flt_kind | output | 2 | Kind of the faulting access |

## Verification
Nested regions are applied: a 64 KB region, a 4 KB region inside it and a 256 B region inside that. Probing addresses in each shell shows whether the highest number wins, as opposed to the smallest or the first region. Every permission code is tried with reads, writes and fetches at both privilege levels, so a swapped or missing table entry shows as a wrong allow. Addresses just outside a 32-byte region, inside a region with an unaligned base, and inside a region with a reserved size code test the mask arithmetic. The same address is then probed before and after toggling the background enable, reprogramming a region and clearing the global enable, which separates the background, runtime-update and bypass paths.

// File: rtl/mem_guard.sv
module mem_guard #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG),
  localparam int ATW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic           ctl_en_in,
  input  logic           ctl_bg_in,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [AW-1:0]  cfg_base,
  input  logic [4:0]     cfg_size,
  input  logic           cfg_en,
  input  logic [ATW-1:0] cfg_attr,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic [1:0]     acc_kind,
  input  logic           acc_priv,
  output logic           acc_ok,
  output logic           hit_valid,
  output logic [IW-1:0]  hit_region,
  output logic [ATW-1:0] hit_attr,
  output logic           flt_valid,
  output logic [AW-1:0]  flt_addr,
  output logic [1:0]     flt_kind
);

  logic            glob_en, bg_en;
  logic [AW-1:0]   r_base [NREG];
  logic [4:0]      r_size [NREG];
  logic            r_en   [NREG];
  logic [ATW-1:0]  r_attr [NREG];
  logic [NREG-1:0] match;
  logic            win_hit;
  logic [IW-1:0]   win;
  logic [ATW-1:0]  sel_attr;
  logic            fetch, wr, perm_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en <= 1'b0;
      bg_en   <= 1'b0;
      for (int i = 0; i < NREG; i++) begin
        r_base[i] <= '0;
        r_size[i] <= '0;
        r_en[i]   <= 1'b0;
        r_attr[i] <= '0;
      end
    end else begin
      if (ctl_we) begin
        glob_en <= ctl_en_in;
        bg_en   <= ctl_bg_in;
      end
      if (cfg_we) begin
        r_base[cfg_idx] <= cfg_base;
        r_size[cfg_idx] <= cfg_size;
        r_en[cfg_idx]   <= cfg_en;
        r_attr[cfg_idx] <= cfg_attr;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_match
    logic [AW-1:0] hi_mask;
    assign hi_mask = (r_size[g] == 5'd31) ? '0
                   : ~((AW'(1) << ({1'b0, r_size[g]} + 6'd1)) - AW'(1));
    assign match[g] = r_en[g] && (r_size[g] >= 5'd4) &&
                      (((acc_addr ^ r_base[g]) & hi_mask) == '0);
  end

  always_comb begin
    win_hit = 1'b0;
    win     = '0;
    for (int i = 0; i < NREG; i++)
      if (match[i]) begin
        win_hit = 1'b1;
        win     = IW'(i);
      end
  end

  assign sel_attr = r_attr[win];
  assign fetch    = acc_kind[1];
  assign wr       = ~acc_kind[1] & acc_kind[0];

  always_comb begin
    case (sel_attr[8:6])
      3'b001:                perm_ok = acc_priv;
      3'b010:                perm_ok = acc_priv | ~wr;
      3'b011:                perm_ok = 1'b1;
      3'b101:                perm_ok = ~wr & acc_priv;
      3'b110, 3'b111:        perm_ok = ~wr;
      default:               perm_ok = 1'b0;
    endcase
  end

  assign acc_ok = !glob_en ? 1'b1
                : win_hit  ? (perm_ok && !(fetch && sel_attr[9]))
                :            (acc_priv && bg_en);

  assign hit_valid  = glob_en & win_hit;
  assign hit_region = hit_valid ? win : '0;
  assign hit_attr   = hit_valid ? sel_attr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
      flt_kind  <= '0;
    end else begin
      flt_valid <= acc_valid & ~acc_ok;
      if (acc_valid && !acc_ok) begin
        flt_addr <= acc_addr;
        flt_kind <= acc_kind;
      end
    end
  end

  p_fault_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ok) |=> (flt_valid && flt_addr == $past(acc_addr) && flt_kind == $past(acc_kind)));

  p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_ok) |=> !flt_valid);

  p_xn_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && acc_kind[1] && hit_attr[9]) |-> !acc_ok);

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> (acc_ok && !hit_valid && hit_attr == '0));

  p_unpriv_bg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && !hit_valid && !acc_priv) |-> !acc_ok);

  p_full_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_attr[8:6] == 3'b011 && !(acc_kind[1] && hit_attr[9])) |-> acc_ok);

endmodule

// File: tb/mem_guard_tb_top.sv
module mem_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 0, ctl_en_in = 0, ctl_bg_in = 0;
  logic        cfg_we = 0, cfg_en = 0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_base = '0;
  logic [4:0]  cfg_size = '0;
  logic [9:0]  cfg_attr = '0;
  logic        acc_valid = 0, acc_priv = 0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_ok, hit_valid, flt_valid;
  logic [2:0]  hit_region;
  logic [9:0]  hit_attr;
  logic [31:0] flt_addr;
  logic [1:0]  flt_kind;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic f; logic [31:0] a; logic [1:0] k; string tag; } exp_t;
  exp_t q[$];

  localparam logic [1:0] RD = 2'b00, WR = 2'b01, IF = 2'b10;

  always #10 clk = ~clk;

  mem_guard dut_i (.*);

  function automatic logic [9:0] mk(input logic xn, input logic [2:0] ap, input logic [2:0] tex,
                                    input logic s, input logic c, input logic b);
    return {xn, ap, tex, s, c, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic [31:0] base, input logic [4:0] sz,
                     input logic en, input logic [9:0] at);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_base = base; cfg_size = sz; cfg_en = en; cfg_attr = at;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ctl(input logic en, input logic bg);
    @(negedge clk);
    ctl_we = 1; ctl_en_in = en; ctl_bg_in = bg;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] k, input logic pv,
                       input logic e_ok, input logic e_hv, input logic [2:0] e_rg,
                       input logic [9:0] e_at, input string tag);
    exp_t it;
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_kind = k; acc_priv = pv;
    #5;
    chk(acc_ok == e_ok, {tag, " ok"}, 64'(acc_ok), 64'(e_ok));
    chk(hit_valid == e_hv && hit_region == e_rg && hit_attr == e_at, {tag, " hit"},
        {hit_valid, hit_region, hit_attr}, {e_hv, e_rg, e_at});
    it.f = pv === pv ? !e_ok : 1'b0; it.a = a; it.k = k; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #3;
    acc_valid = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(flt_valid == it.f, {it.tag, " R9 flt_valid"}, 64'(flt_valid), 64'(it.f));
      if (it.f)
        chk(flt_addr == it.a && flt_kind == it.k, {it.tag, " R9 flt_addr/kind"},
            {flt_addr, flt_kind}, {it.a, it.k});
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] a0, a1, a2, a4, a5, a7;
    a0 = mk(0, 3'b011, 3'b001, 0, 1, 0);
    a1 = mk(1, 3'b010, 3'b000, 1, 0, 0);
    a2 = mk(0, 3'b001, 3'b000, 0, 0, 1);
    a4 = mk(0, 3'b110, 3'b010, 0, 1, 1);
    a5 = mk(0, 3'b011, 3'b000, 1, 1, 1);
    a7 = mk(0, 3'b101, 3'b100, 1, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(flt_valid == 0, "R1 reset flt_valid", 64'(flt_valid), 0);
    apply(32'h0000_0100, WR, 0, 1, 0, 0, 0, "R1/R8 reset bypass");

    cfg(0, 32'h0000_0000, 5'd15, 1, a0);
    cfg(1, 32'h0000_8000, 5'd11, 1, a1);
    cfg(2, 32'h2000_0000, 5'd4,  1, a2);
    cfg(3, 32'h4000_0000, 5'd3,  1, a0);
    cfg(4, 32'h6000_0010, 5'd9,  1, a4);
    cfg(5, 32'h0000_0000, 5'd31, 0, a5);
    cfg(7, 32'h0000_8000, 5'd7,  1, a7);
    ctl(1, 1);

    apply(32'h0000_0100, RD, 0, 1, 1, 0, a0, "R7 attr export read");
    apply(32'h0000_0100, WR, 0, 1, 1, 0, a0, "R5 full write");
    apply(32'h0000_0100, IF, 0, 1, 1, 0, a0, "R6 fetch unified");
    apply(32'h0000_8800, RD, 0, 1, 1, 1, a1, "R3 overlap 1 over 0");
    apply(32'h0000_8800, WR, 0, 0, 1, 1, a1, "R5 ap010 unpriv write");
    apply(32'h0000_8800, WR, 1, 1, 1, 1, a1, "R5 ap010 priv write");
    apply(32'h0000_8800, IF, 1, 0, 1, 1, a1, "R6 xn fetch");
    apply(32'h0000_8010, RD, 1, 1, 1, 7, a7, "R3 overlap 7 wins");
    apply(32'h0000_8010, WR, 1, 0, 1, 7, a7, "R5 ap101 priv write");
    apply(32'h0000_8010, RD, 0, 0, 1, 7, a7, "R5 ap101 unpriv read");
    apply(32'h2000_0010, WR, 1, 1, 1, 2, a2, "R2 32B inside");
    apply(32'h2000_0020, RD, 1, 1, 0, 0, 0, "R2/R4 32B edge priv bg");
    apply(32'h2000_0010, RD, 0, 0, 1, 2, a2, "R5 ap001 unpriv");
    apply(32'h4000_0000, RD, 0, 0, 0, 0, 0, "R2 size code 3 no match");
    apply(32'h6000_03FC, WR, 0, 0, 1, 4, a4, "R2 unaligned base write");
    apply(32'h6000_0000, RD, 0, 1, 1, 4, a4, "R2 unaligned base read");
    apply(32'h6000_0400, RD, 1, 1, 0, 0, 0, "R2 past 1KB priv bg");
    apply(32'hF000_0000, IF, 0, 0, 0, 0, 0, "R1/R4 disabled region unpriv");

    ctl(1, 0);
    apply(32'hF000_0000, RD, 1, 0, 0, 0, 0, "R4 bg off priv");

    cfg(5, 32'h0000_0000, 5'd31, 1, a5);
    apply(32'hF000_0000, RD, 0, 1, 1, 5, a5, "R10 reprogram 4GB");
    apply(32'h0000_8800, WR, 0, 1, 1, 5, a5, "R3 region 5 over 0/1");
    apply(32'h0000_8010, WR, 1, 0, 1, 7, a7, "R3 region 7 over 5");

    cfg(6, 32'h0000_0100, 5'd4, 1, mk(0, 3'b100, 0, 0, 0, 0));
    apply(32'h0000_0100, RD, 1, 0, 1, 6, mk(0, 3'b100, 0, 0, 0, 0), "R5 ap100 none");
    cfg(6, 32'h0000_0100, 5'd4, 1, mk(0, 3'b000, 0, 0, 0, 0));
    apply(32'h0000_0100, RD, 1, 0, 1, 6, mk(0, 3'b000, 0, 0, 0, 0), "R5 ap000 none");
    cfg(6, 32'h0000_0100, 5'd4, 1, mk(0, 3'b111, 0, 0, 0, 0));
    apply(32'h0000_0100, WR, 1, 0, 1, 6, mk(0, 3'b111, 0, 0, 0, 0), "R5 ap111 priv write");
    apply(32'h0000_0100, IF, 0, 1, 1, 6, mk(0, 3'b111, 0, 0, 0, 0), "R6 ap111 unpriv fetch");

    ctl(0, 0);
    apply(32'h0000_8010, WR, 0, 1, 0, 0, 0, "R8 global disable");

    repeat (3) @(posedge clk);
    #5;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule